// File: doc/BRIEF.md
# Display Controller Power-Save Sequencer

This block decides when a display controller may sleep and how far. A mode register selects one of four behaviours. In normal operation the block stays awake. In write-doze it sleeps after a programmable run of cycles with no write. In access-doze it sleeps whenever the CPU is not using display memory. In suspend the controller is parked. While asleep the block gates which CPU cycles are granted at once, which ones stall behind a wait, and which ones are refused.

The outputs drive the neighbouring logic directly. These are a clock divide ratio for the clock generator, a halt for the sequencer, a shutdown enable for blocks that are not needed for refresh, and an enable for video fetch from memory. It also drives the active-low LCD supply control and the LCD pin drive. The way the LCD pins are parked during suspend is set by a strap input that is captured while reset is held.

Top module: `disp_pwr_seq`

## Requirements
- R1: During and after reset the mode is normal (code 0), the block is awake (`pwr_down`=0), `clk_div`=1, `lcd_pwr_n`=0, `lcd_oe`=1, `lcd_low`=0, and CPU requests are granted in the same cycle with `cpu_wait`=0.
- R2: When `mode_wr` is high at a clock edge, `mode_sel` (0 normal, 1 write-doze, 2 access-doze, 3 suspend) takes effect after that edge and the block is awake. The idle counter is reloaded from `idle_limit`.
- R3: In access-doze, an awake block goes to sleep at the next edge. A memory request seen while asleep raises `cpu_wait` with no grant. At the next edge the block wakes and grants the request, and at the edge after that it sleeps again.
- R4: In access-doze, I/O requests are granted in the same cycle while asleep, and the block stays asleep.
- R5: In access-doze, `clk_div` equals `div_ratio` clamped to the range 2..8 while asleep, and equals 1 while awake.
- R6: In write-doze with an idle limit of L, the block sleeps L+1 edges after the last reload if no write occurs. A memory or I/O write reloads the counter.
- R7: In write-doze while asleep, memory and I/O reads are granted in the same cycle without waking. A write raises `cpu_wait` without a grant and wakes the block at the next edge.
- R8: In suspend, memory requests get neither grant nor wait. `vid_mem_en`=0, `seq_halt`=1 and `blk_shutdown`=1. I/O is granted unless `io_lut` is high.
- R9: In suspend `lcd_pwr_n`=1; in every other mode it is 0.
- R10: The strap captured during reset selects the suspend parking. A captured 1 gives `lcd_oe`=1 and `lcd_low`=1, and a captured 0 gives `lcd_oe`=0. Outside suspend `lcd_oe`=1 and `lcd_low`=0.
- R11: `blk_shutdown` is also 1 while asleep in write-doze, and 0 in the other awake or access-doze states. `seq_halt` is 1 only in suspend.
- R12: A memory grant is only given while `clk_div`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_park_low | input | 1 | Parking strap, captured while reset is low |
| mode_wr | input | 1 | Mode register write strobe |
| mode_sel | input | 2 | Mode code to load |
| div_ratio | input | DIV_W | Requested slowdown ratio for access-doze sleep |
| idle_limit | input | IDLE_W | Write-idle interval in cycles |
| mem_req | input | 1 | CPU display memory request |
| mem_wr | input | 1 | Memory request is a write |
| io_req | input | 1 | CPU register I/O request |
| io_wr | input | 1 | I/O request is a write |
| io_lut | input | 1 | I/O targets the lookup-table registers |
| mem_grant | output | 1 | Memory request served this cycle |
| io_grant | output | 1 | I/O request served this cycle |
| cpu_wait | output | 1 | Request stalled while the block wakes |
| pwr_down | output | 1 | Block is asleep or suspended |
| clk_div | output | DIV_W | Clock divide ratio, 1 means full rate |
| seq_halt | output | 1 | Sequencer halt |
| blk_shutdown | output | 1 | Shutdown enable for blocks not needed for refresh |
| vid_mem_en | output | 1 | Video fetch from display memory allowed |
| lcd_pwr_n | output | 1 | Active-low LCD supply control |
| lcd_oe | output | 1 | LCD pin drive enable |
| lcd_low | output | 1 | Force driven LCD pins low |

## Verification
Grants, waits, `clk_div` and the LCD and enable outputs are combinational from the current state and inputs. The bench checks them in the same cycle as the stimulus, after the inputs have settled and well before the next edge. State changes (sleep, wake, mode load) appear exactly one edge after the cause. The write-doze sleep appears L+1 edges after the mode write or the last write. The bench steps one edge at a time and checks after each step, so every result is compared in the cycle it is due and not later.

// File: rtl/disp_pwr_seq.sv
module disp_pwr_seq #(
  parameter int IDLE_W = 16,
  parameter int DIV_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_park_low,
  input  logic              mode_wr,
  input  logic [1:0]        mode_sel,
  input  logic [DIV_W-1:0]  div_ratio,
  input  logic [IDLE_W-1:0] idle_limit,
  input  logic              mem_req,
  input  logic              mem_wr,
  input  logic              io_req,
  input  logic              io_wr,
  input  logic              io_lut,
  output logic              mem_grant,
  output logic              io_grant,
  output logic              cpu_wait,
  output logic              pwr_down,
  output logic [DIV_W-1:0]  clk_div,
  output logic              seq_halt,
  output logic              blk_shutdown,
  output logic              vid_mem_en,
  output logic              lcd_pwr_n,
  output logic              lcd_oe,
  output logic              lcd_low
);
  localparam logic [1:0] M_NORM = 2'd0, M_WDOZE = 2'd1, M_ADOZE = 2'd2, M_SUSP = 2'd3;
  localparam logic [DIV_W-1:0] DIV_ONE = DIV_W'(1), DIV_LO = DIV_W'(2), DIV_HI = DIV_W'(8);

  logic [1:0]        mode_q;
  logic              dn_q;
  logic [IDLE_W-1:0] cnt_q;
  logic              park_q;

  wire in_w = (mode_q == M_WDOZE);
  wire in_a = (mode_q == M_ADOZE);
  wire in_s = (mode_q == M_SUSP);
  wire any_wr = (mem_req & mem_wr) | (io_req & io_wr);

  wire mem_stall = mem_req & dn_q & ((in_a) | (in_w & mem_wr));
  wire io_stall  = io_req & io_wr & dn_q & in_w;

  always_ff @(posedge clk) begin
    if (!rst_n) park_q <= strap_park_low;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= M_NORM;
      dn_q   <= 1'b0;
      cnt_q  <= '0;
    end else if (mode_wr) begin
      mode_q <= mode_sel;
      dn_q   <= 1'b0;
      cnt_q  <= idle_limit;
    end else begin
      case (mode_q)
        M_WDOZE: begin
          if (any_wr) begin
            dn_q  <= 1'b0;
            cnt_q <= idle_limit;
          end else if (!dn_q) begin
            if (cnt_q == '0) dn_q <= 1'b1;
            else cnt_q <= cnt_q - 1'b1;
          end
        end
        M_ADOZE: begin
          if (dn_q) begin
            if (mem_req) dn_q <= 1'b0;
          end else begin
            dn_q <= 1'b1;
          end
        end
        default: dn_q <= 1'b0;
      endcase
    end
  end

  logic [DIV_W-1:0] ratio_c;
  always_comb begin
    if (div_ratio < DIV_LO)      ratio_c = DIV_LO;
    else if (div_ratio > DIV_HI) ratio_c = DIV_HI;
    else                         ratio_c = div_ratio;
  end

  assign cpu_wait     = mem_stall | io_stall;
  assign mem_grant    = mem_req & ~mem_stall & ~in_s;
  assign io_grant     = io_req & ~io_stall & ~(in_s & io_lut);
  assign pwr_down     = dn_q | in_s;
  assign clk_div      = (in_a & dn_q) ? ratio_c : DIV_ONE;
  assign seq_halt     = in_s;
  assign blk_shutdown = in_s | (in_w & dn_q);
  assign vid_mem_en   = ~in_s;
  assign lcd_pwr_n    = in_s;
  assign lcd_oe       = ~in_s | park_q;
  assign lcd_low      = in_s & park_q;
endmodule

module disp_pwr_seq_chk #(
  parameter int DIV_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_wr,
  input logic [1:0]       mode_sel,
  input logic [1:0]       mode_q,
  input logic             dn_q,
  input logic             mem_req,
  input logic             mem_grant,
  input logic [DIV_W-1:0] clk_div,
  input logic             seq_halt,
  input logic             vid_mem_en,
  input logic             lcd_pwr_n
);
  p_mode_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> (mode_q == $past(mode_sel) && !dn_q));
  p_adoze_sleep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'd2 && !dn_q && !mode_wr) |=> dn_q);
  p_adoze_wake_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'd2 && dn_q && mem_req && !mode_wr) |=> !dn_q);
  p_div_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_div >= DIV_W'(1) && clk_div <= DIV_W'(8)));
  p_susp_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'd3) |-> (!mem_grant && seq_halt && !vid_mem_en));
  p_susp_pwr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'd3) |-> lcd_pwr_n);
  p_grant_full_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_grant |-> (clk_div == DIV_W'(1)));
endmodule

bind disp_pwr_seq disp_pwr_seq_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_sel(mode_sel),
  .mode_q(mode_q), .dn_q(dn_q), .mem_req(mem_req), .mem_grant(mem_grant),
  .clk_div(clk_div), .seq_halt(seq_halt), .vid_mem_en(vid_mem_en),
  .lcd_pwr_n(lcd_pwr_n)
);

// File: tb/tb_disp_pwr_seq.sv
module tb_disp_pwr_seq;
  logic clk = 0, rst_n = 0, strap = 0, mode_wr = 0;
  logic [1:0] mode_sel = 0;
  logic [3:0] div_ratio = 0;
  logic [15:0] idle_limit = 0;
  logic mem_req = 0, mem_wr = 0, io_req = 0, io_wr = 0, io_lut = 0;
  logic mem_grant, io_grant, cpu_wait, pwr_down, seq_halt, blk_shutdown;
  logic vid_mem_en, lcd_pwr_n, lcd_oe, lcd_low;
  logic [3:0] clk_div;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #5 clk = ~clk;

  disp_pwr_seq dut (
    .clk(clk), .rst_n(rst_n), .strap_park_low(strap), .mode_wr(mode_wr),
    .mode_sel(mode_sel), .div_ratio(div_ratio), .idle_limit(idle_limit),
    .mem_req(mem_req), .mem_wr(mem_wr), .io_req(io_req), .io_wr(io_wr),
    .io_lut(io_lut), .mem_grant(mem_grant), .io_grant(io_grant),
    .cpu_wait(cpu_wait), .pwr_down(pwr_down), .clk_div(clk_div),
    .seq_halt(seq_halt), .blk_shutdown(blk_shutdown), .vid_mem_en(vid_mem_en),
    .lcd_pwr_n(lcd_pwr_n), .lcd_oe(lcd_oe), .lcd_low(lcd_low)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic do_reset(bit s);
    strap = s; rst_n = 0;
    step(); step();
    rst_n = 1;
    step();
  endtask

  task automatic set_mode(logic [1:0] m, logic [15:0] lim);
    mode_sel = m; idle_limit = lim; mode_wr = 1;
    step();
    mode_wr = 0;
    settle();
  endtask

  task automatic idle();
    mem_req = 0; mem_wr = 0; io_req = 0; io_wr = 0; io_lut = 0;
  endtask

  function automatic int clamp(int r);
    return (r < 2) ? 2 : ((r > 8) ? 8 : r);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    do_reset(1'b0);
    // R1 reset state
    check("R1 pwr_down", pwr_down, 0);
    check("R1 clk_div", clk_div, 1);
    check("R1 lcd_pwr_n", lcd_pwr_n, 0);
    check("R1 lcd_oe", lcd_oe, 1);
    check("R1 lcd_low", lcd_low, 0);
    mem_req = 1; mem_wr = 1; settle();
    check("R1 grant", mem_grant, 1);
    check("R1 wait", cpu_wait, 0);
    idle();

    // R3 R4 R5 R12: sweep all ratios in access-doze
    for (int r = 0; r < 16; r++) begin
      div_ratio = 4'(r);
      set_mode(2'd2, 16'd0);
      check("R2 awake after load", pwr_down, 0);
      check("R5 full rate awake", clk_div, 1);
      step();
      check("R3 sleeps next edge", pwr_down, 1);
      check("R5 clamped ratio", clk_div, clamp(r));
      check("R11 no shutdown adoze", blk_shutdown, 0);
      io_req = 1; io_wr = r[0]; settle();
      check("R4 io granted asleep", io_grant, 1);
      check("R4 no wait for io", cpu_wait, 0);
      step(); io_req = 0; io_wr = 0; settle();
      check("R4 stays asleep", pwr_down, 1);
      mem_req = 1; mem_wr = r[1]; settle();
      check("R3 wait on wake", cpu_wait, 1);
      check("R3 no grant asleep", mem_grant, 0);
      step();
      check("R3 awake", pwr_down, 0);
      check("R3 granted", mem_grant, 1);
      check("R12 full rate on grant", clk_div, 1);
      idle(); step();
      check("R3 back to sleep", pwr_down, 1);
    end

    // R6 sweep idle limits in write-doze
    for (int lim = 0; lim < 7; lim++) begin
      set_mode(2'd1, 16'(lim));
      for (int k = 0; k < lim; k++) begin
        step();
        check("R6 awake before limit", pwr_down, 0);
      end
      step();
      check("R6 asleep at limit+1", pwr_down, 1);
      check("R11 shutdown wdoze asleep", blk_shutdown, 1);
      check("R11 seq not halted", seq_halt, 0);
      check("R11 full rate wdoze", clk_div, 1);
    end

    // R6 reload by writes
    set_mode(2'd1, 16'd3);
    step(); step();
    io_req = 1; io_wr = 1; step(); idle(); settle();
    for (int k = 0; k < 3; k++) begin
      step();
      check("R6 reload holds awake", pwr_down, 0);
    end
    step();
    check("R6 asleep after reload", pwr_down, 1);

    // R7 reads served asleep, writes wake
    mem_req = 1; mem_wr = 0; settle();
    check("R7 mem read granted", mem_grant, 1);
    check("R7 mem read no wait", cpu_wait, 0);
    idle(); io_req = 1; settle();
    check("R7 io read granted", io_grant, 1);
    step(); idle(); settle();
    check("R7 reads keep sleep", pwr_down, 1);
    mem_req = 1; mem_wr = 1; settle();
    check("R7 write waits", cpu_wait, 1);
    check("R7 write not granted", mem_grant, 0);
    step();
    check("R7 woke", pwr_down, 0);
    check("R7 write granted", mem_grant, 1);
    idle();
    set_mode(2'd1, 16'd0); step();
    io_req = 1; io_wr = 1; settle();
    check("R7 io write waits", cpu_wait, 1);
    check("R7 io write held", io_grant, 0);
    idle();

    // R8 R9 R10 suspend with strap 0
    set_mode(2'd3, 16'd0);
    mem_req = 1; settle();
    check("R8 mem blocked", mem_grant, 0);
    check("R8 no wait", cpu_wait, 0);
    check("R8 vid off", vid_mem_en, 0);
    check("R8 seq halt", seq_halt, 1);
    check("R8 shutdown", blk_shutdown, 1);
    mem_req = 0; io_req = 1; io_lut = 0; settle();
    check("R8 io granted", io_grant, 1);
    io_lut = 1; settle();
    check("R8 lut refused", io_grant, 0);
    idle(); settle();
    check("R9 lcd power off", lcd_pwr_n, 1);
    check("R10 tristate", lcd_oe, 0);
    set_mode(2'd0, 16'd0);
    check("R9 lcd power on", lcd_pwr_n, 0);
    check("R10 driven outside suspend", lcd_oe, 1);

    // R10 strap 1
    do_reset(1'b1);
    strap = 0;
    set_mode(2'd3, 16'd0);
    check("R10 drive enabled", lcd_oe, 1);
    check("R10 driven low", lcd_low, 1);
    set_mode(2'd2, 16'd0);
    check("R2 leaves suspend awake", pwr_down, 0);
    check("R10 low released", lcd_low, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule